// File: doc/BRIEF.md
# Double Late Write Synchronous SRAM Front End

This block models the control and data path of a single-port synchronous SRAM that uses a pipelined read and a double late write. It samples every control input on the rising clock edge. Those inputs are a primary enable, two secondary enables, an advance/load select, a write select and per-byte write strobes. From them it decides, on each edge, whether to load a new read, load a new write, continue the running burst or go idle. Read data leaves through a registered output stage one edge after the command. Write data is taken from the bus two edges after the command.

The bidirectional data bus is split into an input port, an output port and an output enable. The bus has no handshake and no back-pressure. Every command is accepted on the edge where it is sampled. Its data moves at a fixed latency, and the host must supply or collect the data at the prescribed edge. The storage is a small behavioural array made of 9-bit bytes, with a write mask for each byte. A burst counter walks the two low address bits in linear order and wraps after four accesses. A read of a location whose write data is still in flight returns the in-flight bytes, so the pipeline stays coherent.

Top module: `dlw_sram_ctrl`

## Requirements
- R1: A new command is accepted only on an edge where `adv` is 0 and all three enables are active. The enables are active when `en1_n` is 0, `en2` equals `EN2_ACT_HI` (default 1) and `en3` equals `EN3_ACT_HI` (default 0). On such an edge `we_n` = 0 starts a write and `we_n` = 1 starts a read. With `adv` = 0 and any enable inactive, the edge is a deselect, and no read or write takes place.
- R2: For a read command sampled at edge n, the addressed word is on `dq_out` with `dq_oe` = 1 after edge n+1.
- R3: For a write command sampled at edge n, the word on `dq_in` is captured at edge n+2. Values on `dq_in` at edges n and n+1 are not stored by that command.
- R4: Bit b of `bw_n` is active low and gates byte b, which is `dq` bits 9b+8 down to 9b. Any combination of strobes is legal. A write with all strobes high is an abort: nothing is stored, but the address is still loaded or advanced for the burst.
- R5: An edge with `adv` = 1 continues the previous read or write. The two low address bits become the base low bits plus the number of continues, modulo 4. The upper address bits keep the loaded value.
- R6: The fourth continue after a load returns to the originally loaded address.
- R7: After a deselect or a write command sampled at edge n, `dq_oe` is 0 after edge n+1.
- R8: A continue issued while the block is deselected keeps it deselected: there is no output and no store.
- R9: Writes and reads may follow each other on consecutive edges, in either order, with no idle cycle between them.
- R10: A read whose output is formed on the same edge at which a pending write to the same address captures its data returns that data, merged byte by byte with the stored word.
- R11: After reset the block is deselected, with `dq_oe` = 0 and `dq_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en1_n | input | 1 | Primary enable, active low |
| en2 | input | 1 | Secondary enable, active level set by EN2_ACT_HI |
| en3 | input | 1 | Secondary enable, active level set by EN3_ACT_HI |
| adv | input | 1 | 0 = load a new address, 1 = continue the burst |
| we_n | input | 1 | 0 = write, 1 = read (used on load edges) |
| bw_n | input | BYTES | Byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | BYTES*BYTE_W | Bus data into the block |
| dq_out | output | BYTES*BYTE_W | Registered read data |
| dq_oe | output | 1 | Output enable for `dq_out` |

## Verification
Two functions can fall on the same edge. One is the capture of a write's data, two edges after its command. The other is the formation of the output for a read issued directly after that write. The bench provokes this by loading a write and then a read of the same address on the next edge. It does this once with all strobes and once with only the upper two bytes. The output after the following edge is then compared with the data driven that edge, or with that data merged into the prior contents. A back-to-back burst of four writes followed at once by a wrapping burst of five reads also overlaps data capture with read output. There, each read beat is judged against the word written at its computed linear address.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/dlw_cmd_decode.sv
module dlw_cmd_decode
  import dlw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter bit EN2_ACT_HI = 1'b1,
  parameter bit EN3_ACT_HI = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3,
  input  logic              adv,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int CNT_W = 2;

  op_e              cur_op;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q, beat_d;
  logic              en_ok;

  assign en_ok = !en1_n && (en2 == EN2_ACT_HI) && (en3 == EN3_ACT_HI);

  always_comb begin
    if (!adv) begin
      cmd_op   = en_ok ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
      cmd_addr = addr;
      beat_d   = '0;
    end else begin
      cmd_op   = cur_op;
      beat_d   = beat_q + 1'b1;
      cmd_addr = {base_q[ADDR_W-1:CNT_W], base_q[CNT_W-1:0] + beat_d};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op <= OP_IDLE;
      base_q <= '0;
      beat_q <= '0;
    end else begin
      cur_op <= cmd_op;
      beat_q <= beat_d;
      if (!adv) base_q <= addr;
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_op == OP_IDLE) |=> (cur_op == OP_IDLE));

  // R6
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_op != OP_IDLE && beat_q == 2'd3) |=> (beat_q == 2'd0));
endmodule

// File: rtl/dlw_write_pipe.sv
module dlw_write_pipe #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTES-1:0]  wr_mask,
  output logic              w2_valid,
  output logic [ADDR_W-1:0] w2_addr,
  output logic [BYTES-1:0]  w2_mask
);
  logic              w1_valid;
  logic [ADDR_W-1:0] w1_addr;
  logic [BYTES-1:0]  w1_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w1_valid <= 1'b0;
      w2_valid <= 1'b0;
      w1_addr  <= '0;
      w2_addr  <= '0;
      w1_mask  <= '0;
      w2_mask  <= '0;
    end else begin
      w1_valid <= is_wr;
      w1_addr  <= wr_addr;
      w1_mask  <= is_wr ? wr_mask : '0;
      w2_valid <= w1_valid;
      w2_addr  <= w1_addr;
      w2_mask  <= w1_mask;
    end
  end
endmodule

// File: rtl/dlw_mem_array.sv
module dlw_mem_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTES-1:0]        wr_mask,
  input  logic [BYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTES*BYTE_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = BYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_mask[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dlw_sram_ctrl.sv
module dlw_sram_ctrl
  import dlw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BYTES      = 4,
  parameter int BYTE_W     = 9,
  parameter bit EN2_ACT_HI = 1'b1,
  parameter bit EN3_ACT_HI = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en1_n,
  input  logic                    en2,
  input  logic                    en3,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [BYTES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] dq_in,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = BYTES * BYTE_W;

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic              w2_valid, mem_we, fwd_hit;
  logic [ADDR_W-1:0] w2_addr;
  logic [BYTES-1:0]  w2_mask;
  logic              rd1_valid;
  logic [ADDR_W-1:0] rd1_addr;
  logic [DATA_W-1:0] rd_word, merged;

  dlw_cmd_decode #(.ADDR_W(ADDR_W), .EN2_ACT_HI(EN2_ACT_HI), .EN3_ACT_HI(EN3_ACT_HI)) u_dec (
    .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3(en3),
    .adv(adv), .we_n(we_n), .addr(addr), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  dlw_write_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .is_wr(cmd_op == OP_WR), .wr_addr(cmd_addr),
    .wr_mask(~bw_n), .w2_valid(w2_valid), .w2_addr(w2_addr), .w2_mask(w2_mask)
  );

  assign mem_we = w2_valid && (|w2_mask);

  dlw_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .wr_en(mem_we), .wr_addr(w2_addr), .wr_mask(w2_mask),
    .wr_data(dq_in), .rd_addr(rd1_addr), .rd_data(rd_word)
  );

  // in-flight write capturing this edge overrides stored bytes
  assign fwd_hit = w2_valid && (w2_addr == rd1_addr);

  for (genvar g = 0; g < BYTES; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = (fwd_hit && w2_mask[g]) ?
        dq_in[g*BYTE_W +: BYTE_W] : rd_word[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd1_valid <= 1'b0;
      rd1_addr  <= '0;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
    end else begin
      rd1_valid <= (cmd_op == OP_RD);
      rd1_addr  <= cmd_addr;
      dq_oe     <= rd1_valid;
      if (rd1_valid) dq_out <= merged;
    end
  end

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_RD) |=> ##1 dq_oe);

  // R7
  hiz_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != OP_RD) |=> ##1 !dq_oe);

  // R3
  late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(cmd_op == OP_WR, 2));
endmodule

// File: tb/tb_dlw_sram_ctrl.sv
module tb_dlw_sram_ctrl;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en1_n, en2, en3, adv, we_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [DW-1:0] G  = 36'hF_0F0F_0F0F;
  localparam logic [DW-1:0] D1 = 36'h1_2345_6789;

  always #2.5 clk = ~clk;

  dlw_sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3(en3), .adv(adv),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic step(input logic e1n, input logic e2, input logic e3, input logic a,
                      input logic wn, input logic [NB-1:0] bwn, input logic [AW-1:0] ad,
                      input logic [DW-1:0] din);
    @(negedge clk);
    en1_n = e1n; en2 = e2; en3 = e3; adv = a; we_n = wn; bw_n = bwn; addr = ad; dq_in = din;
    @(posedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [NB-1:0] bwn, input logic [DW-1:0] din);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bwn, ad, din);
  endtask
  task automatic rd(input logic [AW-1:0] ad, input logic [DW-1:0] din);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, ad, din);
  endtask
  task automatic cont(input logic [NB-1:0] bwn, input logic [DW-1:0] din);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, bwn, '0, din);
  endtask
  task automatic nop(input logic [DW-1:0] din);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, '0, din);
  endtask

  task automatic chk(input string req, input logic exp_oe, input logic [DW-1:0] exp_d);
    #1;
    n_vec++;
    if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp_d)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", req, dq_oe, dq_out, exp_oe, exp_d);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    en1_n = 1'b1; en2 = 1'b1; en3 = 1'b0; adv = 1'b0; we_n = 1'b1;
    bw_n = '1; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; n_vec++;
    if (dq_oe !== 1'b0 || dq_out !== '0) begin
      n_bad++;
      $display("FAIL R11: oe=%0b data=%h expected oe=0 data=0", dq_oe, dq_out);
    end
  endtask

  task automatic t_single;
    wr(6'd5, 4'h0, G);        chk("R7", 1'b0, '0);
    nop(G);
    nop(D1);                   // capture edge, R3
    rd(6'd5, G);
    nop(G);                    chk("R3", 1'b1, D1);
    nop(G);                    chk("R7", 1'b0, '0);
  endtask

  task automatic t_bytes;
    logic [DW-1:0] e = '1;
    e[8:0] = '0; e[26:18] = '0;
    wr(6'd6, 4'h0, G); nop(G); nop('1);
    wr(6'd6, 4'b1010, G); nop(G); nop('0);
    wr(6'd6, 4'b1111, G); nop(G); nop('0);   // abort
    rd(6'd6, G); nop(G);       chk("R4", 1'b1, e);
    // abort on load, continue still advances to base+1
    wr(6'h10, 4'hF, G); cont(4'h0, G); nop(G); nop(36'h3_3333_3333);
    rd(6'h11, G); nop(G);      chk("R4", 1'b1, 36'h3_3333_3333);
  endtask

  task automatic t_burst;
    logic [DW-1:0] d [4];
    for (int i = 0; i < 4; i++) d[i] = 36'hA_0000_0000 + 36'(i * 36'h1_1111);
    wr(6'h0A, 4'h0, G);
    cont(4'h0, G);
    cont(4'h0, d[0]);
    cont(4'h0, d[1]);
    rd(6'h0A, d[2]);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, d[3]); chk("R9", 1'b1, d[0]);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, G);    chk("R5", 1'b1, d[1]);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, G);    chk("R5", 1'b1, d[2]);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, G);    chk("R5", 1'b1, d[3]);
    nop(G);                                             chk("R6", 1'b1, d[0]);
    rd(6'h08, G); nop(G);                               chk("R5", 1'b1, d[2]);
  endtask

  task automatic t_coherent;
    logic [DW-1:0] p = 36'h5_5555_5555;
    logic [DW-1:0] y = 36'hC_3C3C_3C3C;
    logic [DW-1:0] e;
    e = p; e[35:18] = y[35:18];
    wr(6'h21, 4'h0, G); nop(G); nop(p);
    wr(6'h20, 4'h0, G); rd(6'h20, G); nop(36'h7_0F0F_1234); chk("R10", 1'b1, 36'h7_0F0F_1234);
    wr(6'h21, 4'b0011, G); rd(6'h21, G); nop(y);            chk("R10", 1'b1, e);
    nop(G);
    rd(6'h21, G); nop(G);                                   chk("R10", 1'b1, e);
  endtask

  task automatic t_deselect;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 6'd5, G);  // en2 inactive: deselect
    cont(4'h0, G);             chk("R8", 1'b0, '0);
    cont(4'h0, 36'h0_DEAD_BEEF); chk("R8", 1'b0, '0);
    cont(4'h0, 36'h0_DEAD_BEEF); chk("R8", 1'b0, '0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd5, G);  // en3 inactive read
    nop(G);                    chk("R1", 1'b0, '0);
    rd(6'd5, G); nop(G);       chk("R1", 1'b1, D1);
    rd(6'd6, G);
    wr(6'h30, 4'hF, G);        // abort write right after read
    nop(G);                    chk("R7", 1'b0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_bytes();
    t_burst();
    t_coherent();
    t_deselect();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule